// File: doc/BRIEF.md
# Multi-Channel Serial ADC Frame Reader

This block runs a continuous sequence of conversion frames on a group of serial analog-to-digital converters that share one active-low chip-select and one serial clock. Each converter has its own data-out line. All lines are captured in lockstep, one bit on every rising serial-clock edge, with the most significant bit first. At the end of each frame the block presents one right-aligned sample word per channel and pulses a frame-done strobe.

A frame has two parts: a chip-select-low window of `CS_LOW` system-clock cycles and a chip-select-high gap of `CS_HIGH` cycles. The serial clock idles low. It toggles every `HALF` system-clock cycles, and only inside the low window. At run time the frame carries either a short count of pulses (`P_SHORT`, 14 by default) or a long count (`P_LONG`, 16 by default). The pulse count is fixed for the whole frame. Elaboration stops if the low window cannot hold the long pulse train with margin for capture.

When enable goes low, the frame in progress runs to completion. The outputs then park with chip-select high and the serial clock low. After reset, chip-select is high and the serial clock is low before any frame begins.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, cs_n is 1, sclk is 0, frame_done is 0 and every sample word is zero.
- R2: With enable held high, cs_n stays low for exactly CS_LOW cycles and high for exactly CS_HIGH cycles in each frame. At the defaults (70 and 12 cycles) and a 100 MHz clock, this gives 700 ns and 120 ns.
- R3: With len_sel = 0 at frame start, a frame carries exactly P_SHORT (14) sclk pulses. Each pulse is high for HALF cycles, and the first rising edge comes HALF cycles after cs_n falls.
- R4: With len_sel = 1 at frame start, a frame carries exactly P_LONG (16) sclk pulses with the same pulse shape.
- R5: sclk is 0 whenever cs_n is 1.
- R6: cs_n rises only after the last sclk falling edge of the frame, with sclk already low for at least one cycle.
- R7: Each channel's data line is sampled at every sclk rising edge, MSB first. The sample word is right-aligned: bit 0 holds the last bit sampled, and the bits above the pulse count read zero.
- R8: Each channel's sample word comes only from its own data line. Channel k occupies samples[k*WORD_W +: WORD_W].
- R9: frame_done is high for exactly one cycle, in the cycle cs_n returns high. The sample words update in that same cycle and hold until the next frame_done.
- R10: len_sel is sampled only while cs_n is high. A change while cs_n is low alters the pulse count of the next frame, not the current one.
- R11: If enable is deasserted, the current frame completes with valid data. cs_n then stays high and sclk stays low. When enable is reasserted, frames resume, each starting after a CS_HIGH gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run frames while high |
| len_sel | input | 1 | 0: short frame, 1: long frame |
| sdo | input | NUM_CH | Data-out line of each converter |
| cs_n | output | 1 | Shared active-low chip-select |
| sclk | output | 1 | Shared serial clock |
| samples | output | NUM_CH*WORD_W | Packed per-channel sample words |
| frame_done | output | 1 | One-cycle strobe when samples update |

## Verification
Two situations are hard to reach from the ports: a change of the frame-length select in the middle of a frame, and a drop of enable while chip-select is low. The bench waits for the chip-select falling edge and then changes the select a few cycles into the low window. It confirms that the frame in progress keeps its pulse count and that the next frame uses the new one. The bench also drops enable inside a low window. It checks that this frame still delivers correct data and that no further chip-select or clock activity appears over a long idle stretch. A converter model in the bench shifts a known word out on every falling clock edge, so every bit position of every channel is checked against a value fixed in advance.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GAP  = 2'd1,
      ST_LOW  = 2'd2
   } rd_state_t;
endpackage

// File: rtl/adc_frame_timer.sv
module adc_frame_timer
   import adc_rd_pkg::*;
#(
   parameter int HALF    = 2,
   parameter int CS_LOW  = 70,
   parameter int CS_HIGH = 12,
   parameter int P_SHORT = 14,
   parameter int P_LONG  = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic enable,
   input  logic len_sel,
   output logic cs_n,
   output logic sclk,
   output logic rise,
   output logic frame_end
);
   localparam int LW = $clog2(CS_LOW + 1);
   localparam int GW = $clog2(CS_HIGH + 1);
   localparam int HW = $clog2(HALF + 1);
   localparam int EW = $clog2(2 * P_LONG + 1);
   localparam logic [LW-1:0] LOW_LAST  = LW'(CS_LOW - 1);
   localparam logic [GW-1:0] GAP_LAST  = GW'(CS_HIGH - 1);
   localparam logic [HW-1:0] HALF_LAST = HW'(HALF - 1);
   localparam logic [EW-1:0] EDGES_SHORT = EW'(2 * P_SHORT);
   localparam logic [EW-1:0] EDGES_LONG  = EW'(2 * P_LONG);

   rd_state_t     st;
   logic [LW-1:0] low_cnt;
   logic [GW-1:0] gap_cnt;
   logic [HW-1:0] half_cnt;
   logic [EW-1:0] edges;
   logic          len_q;
   logic          cs_q;
   logic          sclk_q;
   logic          rise_q;
   logic [EW-1:0] edge_target;

   assign edge_target = len_q ? EDGES_LONG : EDGES_SHORT;

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_IDLE;
         low_cnt  <= '0;
         gap_cnt  <= '0;
         half_cnt <= '0;
         edges    <= '0;
         len_q    <= 1'b0;
         cs_q     <= 1'b1;
         sclk_q   <= 1'b0;
         rise_q   <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               len_q <= len_sel;
               if (enable) begin
                  st      <= ST_GAP;
                  gap_cnt <= '0;
               end
            end
            ST_GAP: begin
               len_q <= len_sel;
               if (!enable) begin
                  st <= ST_IDLE;
               end else if (gap_cnt == GAP_LAST) begin
                  st       <= ST_LOW;
                  cs_q     <= 1'b0;
                  low_cnt  <= '0;
                  half_cnt <= '0;
                  edges    <= '0;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            ST_LOW: begin
               if (half_cnt == HALF_LAST) begin
                  half_cnt <= '0;
                  if (edges < edge_target) begin
                     sclk_q <= ~sclk_q;
                     rise_q <= ~sclk_q;
                     edges  <= edges + 1'b1;
                  end
               end else begin
                  half_cnt <= half_cnt + 1'b1;
               end
               if (low_cnt == LOW_LAST) begin
                  cs_q    <= 1'b1;
                  gap_cnt <= '0;
                  st      <= enable ? ST_GAP : ST_IDLE;
               end else begin
                  low_cnt <= low_cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cs_n      = cs_q;
   assign sclk      = sclk_q;
   assign rise      = rise_q;
   assign frame_end = (st == ST_LOW) && (low_cnt == LOW_LAST);

   assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (rst)
      cs_q |-> !sclk_q);
   assert_cs_after_fall_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_q) |-> ($past(!sclk_q) && !sclk_q));
   assert_len_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!cs_q && $past(!cs_q)) |-> $stable(len_q));
   assert_park_R11: assert property (@(posedge clk) disable iff (rst)
      (cs_q && !enable) |=> cs_q);
endmodule

// File: rtl/adc_chan_capture.sv
module adc_chan_capture #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sdo,
   input  logic              rise,
   input  logic              frame_end,
   output logic [WORD_W-1:0] word
);
   logic              sync1;
   logic              sync2;
   logic              rise_d;
   logic [WORD_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync1  <= 1'b0;
         sync2  <= 1'b0;
         rise_d <= 1'b0;
         shreg  <= '0;
         word   <= '0;
      end else begin
         sync1  <= sdo;
         sync2  <= sync1;
         rise_d <= rise;
         if (frame_end) begin
            word  <= shreg;
            shreg <= '0;
         end else if (rise_d) begin
            shreg <= {shreg[WORD_W-2:0], sync2};
         end
      end
   end

   assert_no_shift_at_end_R7: assert property (@(posedge clk) disable iff (rst)
      frame_end |-> !rise_d);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
   parameter int NUM_CH  = 4,
   parameter int WORD_W  = 16,
   parameter int HALF    = 2,
   parameter int CS_LOW  = 70,
   parameter int CS_HIGH = 12,
   parameter int P_SHORT = 14,
   parameter int P_LONG  = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     enable,
   input  logic                     len_sel,
   input  logic [NUM_CH-1:0]        sdo,
   output logic                     cs_n,
   output logic                     sclk,
   output logic [NUM_CH*WORD_W-1:0] samples,
   output logic                     frame_done
);
   localparam int MIN_LOW = 2 * P_LONG * HALF + 2;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (HALF < 1) begin : g_bad_half
      $error("HALF must be at least 1");
   end
   if (CS_HIGH < 1) begin : g_bad_high
      $error("CS_HIGH must be at least 1");
   end
   if (P_SHORT < 1 || P_SHORT > P_LONG) begin : g_bad_pulses
      $error("P_SHORT must lie between 1 and P_LONG");
   end
   if (WORD_W < P_LONG || WORD_W < 2) begin : g_bad_word
      $error("WORD_W cannot hold the long frame");
   end
   if (CS_LOW < MIN_LOW) begin : g_bad_low
      $error("CS_LOW too short for the long pulse train");
   end

   logic rise;
   logic frame_end;
   logic done_q;

   adc_frame_timer #(
      .HALF(HALF), .CS_LOW(CS_LOW), .CS_HIGH(CS_HIGH),
      .P_SHORT(P_SHORT), .P_LONG(P_LONG)
   ) timer_i (
      .clk(clk), .rst(rst), .enable(enable), .len_sel(len_sel),
      .cs_n(cs_n), .sclk(sclk), .rise(rise), .frame_end(frame_end)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [WORD_W-1:0] ch_word;
      adc_chan_capture #(.WORD_W(WORD_W)) cap_i (
         .clk(clk), .rst(rst), .sdo(sdo[ch]), .rise(rise),
         .frame_end(frame_end), .word(ch_word)
      );
      assign samples[ch*WORD_W +: WORD_W] = ch_word;
   end

   always_ff @(posedge clk) begin
      if (rst) done_q <= 1'b0;
      else     done_q <= frame_end;
   end
   assign frame_done = done_q;

   assert_done_with_cs_R9: assert property (@(posedge clk) disable iff (rst)
      done_q |-> cs_n);
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);
   assert_hold_samples_R9: assert property (@(posedge clk) disable iff (rst)
      !done_q |-> $stable(samples));
endmodule

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;
   localparam int NCH = 4;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic enable = 1'b0;
   logic len_sel = 1'b0;
   logic [NCH-1:0] sdo = '0;
   logic cs_n;
   logic sclk;
   logic [NCH*W-1:0] samples;
   logic frame_done;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [W-1:0] mword [NCH];
   logic [W-1:0] msh [NCH];
   int model_n = 14;

   int rises = 0;
   int last_rises = 0;
   time t_csfall = 0, t_csrise = 0, t_low = 0, t_high = 0;
   time t_srise = 0, t_sfall = 0;
   int width_bad = 0;
   int idle_bad = 0;
   int order_bad = 0;

   always #5 clk = ~clk;

   adc_frame_reader dut_i (
      .clk(clk), .rst(rst), .enable(enable), .len_sel(len_sel), .sdo(sdo),
      .cs_n(cs_n), .sclk(sclk), .samples(samples), .frame_done(frame_done)
   );

   // converter model: MSB first, next bit on every falling clock edge
   always @(negedge cs_n) begin
      for (int c = 0; c < NCH; c++) begin
         msh[c] = mword[c] << (W - model_n);
         sdo[c] = msh[c][W-1];
      end
      rises = 0;
      t_csfall = $time;
      if (t_csrise != 0) t_high = t_csfall - t_csrise;
   end
   always @(negedge sclk) begin
      if (!rst) begin
         for (int c = 0; c < NCH; c++) begin
            msh[c] = msh[c] << 1;
            sdo[c] = msh[c][W-1];
         end
         t_sfall = $time;
         if (t_sfall - t_srise != 20) width_bad++;
      end
   end
   always @(posedge sclk) begin
      rises++;
      t_srise = $time;
      if (rises == 1 && t_srise - t_csfall != 20) width_bad++;
   end
   always @(posedge cs_n) begin
      if (!rst) begin
         last_rises = rises;
         t_csrise = $time;
         t_low = t_csrise - t_csfall;
         if (sclk || (t_csrise - t_sfall) < 10) order_bad++;
      end
   end
   always @(negedge clk) if (!rst && cs_n && sclk) idle_bad++;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_done();
      @(posedge frame_done);
      @(negedge clk);
   endtask

   task automatic check_words(input string tag);
      for (int c = 0; c < NCH; c++) begin
         logic [W-1:0] e;
         e = mword[c] & W'((32'h1 << model_n) - 1);
         check(samples[c*W +: W] == e, tag, samples[c*W +: W], e);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(cs_n == 1'b1 && sclk == 1'b0 && frame_done == 1'b0, "R1 idle pins", {cs_n, sclk, frame_done}, 3'b100);
      rst = 1'b0;
      @(negedge clk);
      check(cs_n == 1'b1 && sclk == 1'b0, "R1 after release", {cs_n, sclk}, 2'b10);
      check(samples == '0, "R1 samples zero", samples, 0);
   endtask

   task automatic t_short();
      mword[0] = 16'hA5C3; mword[1] = 16'h3C96; mword[2] = 16'hFFFF; mword[3] = 16'h0001;
      model_n = 14; len_sel = 1'b0; enable = 1'b1;
      wait_done();
      check(last_rises == 14, "R3 short pulse count", last_rises, 14);
      check_words("R7 R8 short data");
      check(t_low == 700, "R2 cs low time", t_low, 700);
      @(negedge clk);
      check(frame_done == 1'b0, "R9 done one cycle", frame_done, 0);
      mword[0] = 16'h1234; mword[1] = 16'h2AAA; mword[2] = 16'h0000; mword[3] = 16'h3FFE;
      repeat (20) @(negedge clk);
      check(samples[W-1:0] == 16'h25C3, "R9 samples held", samples[W-1:0], 16'h25C3);
      wait_done();
      check(t_high == 120, "R2 cs high time", t_high, 120);
      check_words("R7 R8 second frame");
   endtask

   task automatic t_long();
      len_sel = 1'b1; model_n = 16;
      mword[0] = 16'h8001; mword[1] = 16'hC33C; mword[2] = 16'h7F00; mword[3] = 16'hFFFF;
      wait_done();
      check(last_rises == 16, "R4 long pulse count", last_rises, 16);
      check_words("R4 R7 long data");
   endtask

   task automatic t_midchange();
      @(negedge cs_n);
      repeat (5) @(negedge clk);
      len_sel = 1'b0;
      wait_done();
      check(last_rises == 16, "R10 current frame kept", last_rises, 16);
      check_words("R10 current frame data");
      model_n = 14;
      wait_done();
      check(last_rises == 14, "R10 next frame short", last_rises, 14);
      check_words("R10 next frame data");
   endtask

   task automatic t_disable();
      int cs_low_seen = 0;
      int sclk_seen = 0;
      mword[0] = 16'h0F0F; mword[1] = 16'h1111; mword[2] = 16'h2222; mword[3] = 16'h3333;
      @(negedge cs_n);
      repeat (10) @(negedge clk);
      enable = 1'b0;
      wait_done();
      check(last_rises == 14, "R11 frame completes", last_rises, 14);
      check_words("R11 final data");
      repeat (200) begin
         @(negedge clk);
         if (!cs_n) cs_low_seen++;
         if (sclk) sclk_seen++;
      end
      check(cs_low_seen == 0 && sclk_seen == 0, "R11 parked", cs_low_seen + sclk_seen, 0);
      mword[0] = 16'h3ABC;
      enable = 1'b1;
      wait_done();
      check_words("R11 resume data");
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NCH; c++) mword[c] = '0;
      t_reset();
      t_short();
      t_long();
      t_midchange();
      t_disable();
      check(width_bad == 0, "R3 pulse shape", width_bad, 0);
      check(idle_bad == 0, "R5 sclk idle", idle_bad, 0);
      check(order_bad == 0, "R6 cs after last fall", order_bad, 0);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule